// File: doc/BRIEF.md
# 8-bit Add/Subtract Unit with Carry-Chain Flags

This unit is the adder/subtractor of an 8-bit accumulator-style CPU core. On each enabled clock edge it combines operand A and operand B under one of four operations (plain add, add with carry, plain subtract, subtract with borrow). It then registers the 8-bit result and a new flags byte. The flags byte carries zero, subtract, half-carry and carry bits.

The carry (or borrow) input comes from the core's current carry flag. It enters the arithmetic as its own third term in a 9-bit sum or difference. It is never merged into operand B first. So cases where B is 0xFF and the carry is set still give the right carry and half-carry. The decoder drives the operation select and write enable. The core's flag register feeds the current carry back in.

Top module: `addsub8_unit`

## Requirements
- R1: While rst_ni is low, res_o and flags_o are both 0x00.
- R2: op_i encodes 0=ADD, 1=ADC, 2=SUB, 3=SBC. For ADD the next res_o is (A+B) mod 256. Carry (flags bit 4) is bit 8 of the 9-bit sum. Half-carry (flags bit 5) is set when the low nibbles plus carry-in exceed 15.
- R3: ADC adds carry_i as a separate 1-bit term to the 9-bit sum A+B+carry_i. 0x01 ADC 0xFE gives 0x00 with flags 0xB0 when carry_i=1, and 0xFF with flags 0x00 when carry_i=0.
- R4: SUB gives (A-B) mod 256 and sets N (flags bit 6). It sets H when A[3:0] < B[3:0]. It sets C when A < B.
- R5: SBC subtracts carry_i as a separate borrow term. C is set when A < B+carry_i and H when A[3:0] < B[3:0]+carry_i. For example, 0x00 SBC 0xFF with borrow gives 0x00 with flags 0xF0.
- R6: ADD and SUB ignore carry_i. The same operands give the same result and flags whether carry_i is 0 or 1.
- R7: Z (flags bit 7) is set exactly when the 8-bit result is zero. ADD and ADC clear N.
- R8: Bits 3..0 of flags_o always read zero.
- R9: When en_i is low at a clock edge, res_o and flags_o keep their values.
- R10: Results are registered. An enabled operation appears on res_o and flags_o after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Write enable for result and flags |
| op_i | input | 2 | Operation select (0 ADD, 1 ADC, 2 SUB, 3 SBC) |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| carry_i | input | 1 | Current carry flag of the core |
| res_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered flags {Z,N,H,C,0000} |

## Verification
Every result and flags value is due exactly one rising edge after the inputs that produce it. The bench drives each stimulus on a falling edge and samples the outputs on the following falling edge. Each comparison therefore falls half a period after the only register stage.

One directed check samples just after a new stimulus, before the edge, to confirm nothing leaks through combinationally. Disabled cycles are checked against the value held from the last enabled edge.

// File: rtl/addsub8_pkg.sv
package addsub8_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_ADC = 2'd1,
    OP_SUB = 2'd2,
    OP_SBC = 2'd3
  } op_e;

  localparam int unsigned FLAG_Z = 7;
  localparam int unsigned FLAG_N = 6;
  localparam int unsigned FLAG_H = 5;
  localparam int unsigned FLAG_C = 4;
endpackage

// File: rtl/addsub8_core.sv
module addsub8_core #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         half_o
);
  localparam int unsigned HB = W / 2;

  logic [W:0] s;

  // carry/borrow-in kept as a third term at full width
  always_comb begin
    if (sub_i) s = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    else       s = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  end

  assign res_o  = s[W-1:0];
  assign cout_o = s[W];
  // carry (or borrow) into bit HB
  assign half_o = a_i[HB] ^ b_i[HB] ^ s[HB];
endmodule

// File: rtl/addsub8_flags.sv
module addsub8_flags
  import addsub8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         sub_i,
  input  logic         cout_i,
  input  logic         half_i,
  output logic [7:0]   flags_o
);
  always_comb begin
    flags_o         = '0;
    flags_o[FLAG_Z] = (res_i == '0);
    flags_o[FLAG_N] = sub_i;
    flags_o[FLAG_H] = half_i;
    flags_o[FLAG_C] = cout_i;
  end
endmodule

// File: rtl/addsub8_unit.sv
module addsub8_unit
  import addsub8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic [7:0]   flags_o
);
  op_e        op;
  logic       use_cin, is_sub, cout, half;
  logic [W-1:0] res_d;
  logic [7:0] flags_d;

  assign op      = op_e'(op_i);
  assign use_cin = (op == OP_ADC) || (op == OP_SBC);
  assign is_sub  = (op == OP_SUB) || (op == OP_SBC);

  addsub8_core #(.W(W)) u_core (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (use_cin & carry_i),
    .sub_i (is_sub),
    .res_o (res_d),
    .cout_o(cout),
    .half_o(half)
  );

  addsub8_flags #(.W(W)) u_flags (
    .res_i  (res_d),
    .sub_i  (is_sub),
    .cout_i (cout),
    .half_i (half),
    .flags_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      flags_o <= '0;
    end else if (en_i) begin
      res_o   <= res_d;
      flags_o <= flags_d;
    end
  end
endmodule

// File: rtl/addsub8_chk.sv
module addsub8_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [1:0] op_i,
  input logic [7:0] a_i,
  input logic [7:0] b_i,
  input logic       carry_i,
  input logic [7:0] res_o,
  input logic [7:0] flags_o
);
  // R8
  low_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[3:0] == 4'h0);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(res_o) && $stable(flags_o));

  // R7
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> flags_o[7] == (res_o == 8'h00));

  // R7
  add_n_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !op_i[1] |=> !flags_o[6]);

  // R4
  sub_n_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i[1] |=> flags_o[6]);

  // R6
  add_zero_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == 2'd0 && b_i == 8'h00 |=> !flags_o[4] && res_o == $past(a_i));

  // R5
  sbc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == 2'd3 && carry_i && b_i == 8'hFF |=> flags_o[4]);
endmodule

bind addsub8_unit addsub8_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .carry_i(carry_i),
  .res_o  (res_o),
  .flags_o(flags_o)
);

// File: tb/addsub8_unit_tb.sv
`timescale 1ns/1ps
module addsub8_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [7:0] a_i = 8'h00, b_i = 8'h00;
  logic       carry_i = 1'b0;
  logic [7:0] res_o, flags_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_res = 8'h00, exp_fl = 8'h00;

  always #2.5 clk_i = ~clk_i;

  addsub8_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .res_o(res_o), .flags_o(flags_o)
  );

  function automatic logic [15:0] model(input int op, input int a, input int b, input int c);
    int cin, s, r, z, n, h, cy;
    cin = (op == 1 || op == 3) ? c : 0;
    if (op < 2) begin
      s  = a + b + cin;
      h  = ((a % 16) + (b % 16) + cin) > 15;
      cy = s > 255;
      n  = 0;
    end else begin
      s  = a - b - cin;
      h  = (a % 16) < ((b % 16) + cin);
      cy = s < 0;
      n  = 1;
    end
    r = (s + 512) % 256;
    z = (r == 0);
    return {8'(r), 8'(z * 128 + n * 64 + h * 32 + cy * 16)};
  endfunction

  task automatic cmp(input string tag, input logic [7:0] er, input logic [7:0] ef);
    total++;
    if (res_o !== er || flags_o !== ef) begin
      bad++;
      $display("FAIL %s: res=%h flags=%h expected res=%h flags=%h", tag, res_o, flags_o, er, ef);
    end
  endtask

  // drive at negedge, sample at next negedge (one register stage)
  task automatic step(input int op, input int a, input int b, input bit c, input bit en, input string tag);
    logic [15:0] m;
    op_i = 2'(op); a_i = 8'(a); b_i = 8'(b); carry_i = c; en_i = en;
    @(posedge clk_i);
    @(negedge clk_i);
    if (en) begin
      m = model(op, a, b, c);
      exp_res = m[15:8];
      exp_fl  = m[7:0];
    end
    cmp(tag, exp_res, exp_fl);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cmp("R1 reset", 8'h00, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 documented ADC pair
    step(1, 8'h01, 8'hFE, 1, 1, "R3 adc cin1");
    cmp("R3 adc 0x01+0xFE+1", 8'h00, 8'hB0);
    step(1, 8'h01, 8'hFE, 0, 1, "R3 adc cin0");
    cmp("R3 adc 0x01+0xFE+0", 8'hFF, 8'h00);
    step(1, 8'h00, 8'hFF, 1, 1, "R3 adc b=FF with carry");
    // R5 borrow not folded into B
    step(3, 8'h00, 8'hFF, 1, 1, "R5 sbc b=FF with borrow");
    cmp("R5 sbc 0x00-0xFF-1", 8'h00, 8'hF0);
    // R6 carry ignored by ADD and SUB
    step(0, 8'h01, 8'hFE, 1, 1, "R6 add ignores carry");
    cmp("R6 add 0x01+0xFE", 8'hFF, 8'h00);
    step(2, 8'h10, 8'h01, 1, 1, "R6 sub ignores carry");
    cmp("R6 sub 0x10-0x01", 8'h0F, 8'h60);
    step(2, 8'h42, 8'h42, 0, 1, "R7 sub zero result");
    cmp("R7 zero after sub", 8'h00, 8'hC0);
    // R9 disabled edge holds
    step(0, 8'h33, 8'h44, 0, 0, "R9 hold");
    // R10 no combinational path before the edge
    op_i = 2'd0; a_i = 8'h05; b_i = 8'h06; carry_i = 1'b0; en_i = 1'b1;
    #1;
    cmp("R10 before edge", exp_res, exp_fl);
    @(posedge clk_i);
    @(negedge clk_i);
    exp_res = 8'h0B; exp_fl = 8'h00;
    cmp("R10 after edge", 8'h0B, 8'h00);

    // nibble corner sweep, all ops and carry values
    for (int op = 0; op < 4; op++)
      for (int c = 0; c < 2; c++)
        for (int an = 0; an < 16; an++)
          for (int bn = 0; bn < 16; bn++)
            step(op, an * 17, bn * 16 + 15 - bn, c[0], 1,
                 op == 0 ? "R2 nibble add" : op == 1 ? "R3 nibble adc" :
                 op == 2 ? "R4 nibble sub" : "R5 nibble sbc");

    // full operand sweep with mixed ops, carry, enable (R2 R3 R4 R5 R8 R9)
    for (int i = 0; i < 65536; i++) begin
      int op;
      bit c, en;
      op = (i ^ (i >> 8) ^ (i >> 3)) & 3;
      c  = ((i >> 2) ^ (i >> 11)) & 1;
      en = (i % 29) != 7;
      step(op, i & 255, (i >> 8) & 255, c, en,
           !en ? "R9 sweep hold" : op == 0 ? "R2 sweep add" : op == 1 ? "R3 sweep adc" :
           op == 2 ? "R4 sweep sub" : "R5 sweep sbc");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule